// File: doc/BRIEF.md
# Slave Dual B-Channel Frame Timer

This block drives the local PCM port on the slave side of a digital loop link. A programmable divider derives a bit clock from the system clock. A bit counter built on that clock splits every frame into two 8-bit B-channel windows, one after the other, followed by an idle tail. One enable output marks each window. The first enable is high at the start of every frame, so it also serves as the 8 kHz frame reference. Two parallel bytes go out MSB first on one serial output. Two received bytes are gathered from one serial input and presented in parallel.

While the tone input is high, each received byte is replaced by a PCM code that alternates between two fixed values every eight frames. This gives audible feedback at 500 Hz when the frame rate is 8 kHz. A burst watchdog counts system clock cycles since the last good-burst pulse. Its expired state is copied to a loss flag only at the start of each frame. Downstream power control uses that flag.

Top module: `pcm_slave_timer`

## Requirements
- R1: Each bit clock half-period lasts div_i+1 system clock cycles. The bit clock is low out of reset.
- R2: While rst_ni is low, bclk_o, en1_o, en2_o, tx_o, lost_o, rx1_o and rx2_o are all 0.
- R3: A frame is FRAME_BITS bit clock periods. The first rising edge of the bit clock after reset starts bit 0. en1_o is high for bits 0 to 7 and en2_o for bits 8 to 15. Both are low for the remaining bits. The enables change only on rising edges of the bit clock and are never high together.
- R4: tx_o changes only on rising edges of the bit clock. In bits 0 to 7 it carries tx1_i MSB first. In bits 8 to 15 it carries tx2_i MSB first. In all other bits it is 0. Both bytes are sampled at the rising edge that starts bit 0.
- R5: rx_i is sampled on falling edges of the bit clock, MSB first. rx1_o loads on the falling edge that ends bit 7 and rx2_o on the falling edge that ends bit 15. The input during bits 16 and later is ignored, and both outputs hold between updates.
- R6: If tone_i is high at one of those loading edges, the register loads a tone code in place of the received byte. Frames are counted from 0, starting with the first frame after reset. When the frame count modulo 16 is below 8, the code is TONE_A. Otherwise it is TONE_B.
- R7: The watchdog counts system clock cycles since the last cycle in which good_burst_i was high, or since reset. The watchdog is expired once that count reaches TIMEOUT.
- R8: lost_o changes only at the edge where en1_o rises. It takes the expired state from before that edge. A good-burst pulse sampled at that same edge does not affect this update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Half-period of the bit clock minus one, in system clock cycles |
| good_burst_i | input | 1 | One-cycle pulse for each correctly received burst |
| tone_i | input | 1 | Replace received bytes with the tone code |
| rx_i | input | 1 | Serial receive data |
| tx1_i | input | 8 | Channel 1 byte to send |
| tx2_i | input | 8 | Channel 2 byte to send |
| bclk_o | output | 1 | Bit clock |
| en1_o | output | 1 | Channel 1 window, also the frame reference |
| en2_o | output | 1 | Channel 2 window |
| tx_o | output | 1 | Serial transmit data |
| rx1_o | output | 8 | Last channel 1 byte received, or the tone code |
| rx2_o | output | 8 | Last channel 2 byte received, or the tone code |
| lost_o | output | 1 | Burst loss flag, updated at frame start |

## Verification
A good-burst pulse can clear the watchdog in the same system clock edge where the frame-start update samples it into lost_o. To provoke this, the bench places a pulse exactly on every fourth frame-start edge and sends no other pulses, so the gap before each such pulse exceeds TIMEOUT. At that edge lost_o must still report 1. One frame later it must report 0.

// File: rtl/pcm_slave_pkg.sv
package pcm_slave_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {SLOT_B1, SLOT_B2, SLOT_IDLE} slot_e;

  function automatic slot_e slot_of(input int unsigned idx);
    if (idx < BYTE_W)        return SLOT_B1;
    else if (idx < 2*BYTE_W) return SLOT_B2;
    else                     return SLOT_IDLE;
  endfunction
endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] half_q;
  logic             bclk_q;
  logic             tick;

  assign tick   = (half_q >= div_i);
  assign rise_o = tick & ~bclk_q;
  assign fall_o = tick & bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      half_q <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      half_q <= half_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_slave_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] bit_q_o,
  output logic [CNT_W-1:0] bit_nxt_o,
  output logic             sof_o,
  output logic             tone_sel_o,
  output logic             en1_o,
  output logic             en2_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] bit_q;
  logic [CNT_W-1:0] bit_nxt;
  logic [3:0]       frm_q;
  logic             en1_q, en2_q;

  assign bit_nxt    = (bit_q == LAST) ? '0 : bit_q + 1'b1;
  assign sof_o      = rise_i && (bit_nxt == '0);
  assign bit_q_o    = bit_q;
  assign bit_nxt_o  = bit_nxt;
  assign tone_sel_o = frm_q[3];
  assign en1_o      = en1_q;
  assign en2_o      = en2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= LAST;
      frm_q <= 4'hF;
      en1_q <= 1'b0;
      en2_q <= 1'b0;
    end else if (rise_i) begin
      bit_q <= bit_nxt;
      en1_q <= (slot_of(32'(bit_nxt)) == SLOT_B1);
      en2_q <= (slot_of(32'(bit_nxt)) == SLOT_B2);
      if (bit_nxt == '0) frm_q <= frm_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_serdes.sv
module pcm_serdes
  import pcm_slave_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter byte_t       TONE_A = 8'h2A,
  parameter byte_t       TONE_B = 8'hAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] bit_q_i,
  input  logic [CNT_W-1:0] bit_nxt_i,
  input  logic             tone_sel_i,
  input  logic             tone_i,
  input  logic             rx_i,
  input  byte_t            tx1_i,
  input  byte_t            tx2_i,
  output logic             tx_o,
  output byte_t [1:0]      rx_o
);
  byte_t hold1_q, hold2_q, sh_q;
  logic  tx_q;
  byte_t tone_code;
  byte_t rx_word;

  assign tone_code = tone_sel_i ? TONE_B : TONE_A;
  assign rx_word   = {sh_q[BYTE_W-2:0], rx_i};
  assign tx_o      = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= 1'b0;
      hold1_q <= '0;
      hold2_q <= '0;
    end else if (rise_i) begin
      unique case (slot_of(32'(bit_nxt_i)))
        SLOT_B1: begin
          if (bit_nxt_i == '0) begin
            tx_q    <= tx1_i[BYTE_W-1];
            hold1_q <= tx1_i;
            hold2_q <= tx2_i;
          end else begin
            tx_q <= hold1_q[3'd7 - bit_nxt_i[2:0]];
          end
        end
        SLOT_B2: tx_q <= hold2_q[3'd7 - bit_nxt_i[2:0]];
        default: tx_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           sh_q <= '0;
    else if (fall_i && slot_of(32'(bit_q_i)) != SLOT_IDLE) sh_q <= rx_word;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_rx
    localparam logic [CNT_W-1:0] END_BIT = CNT_W'(BYTE_W*ch + BYTE_W - 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           rx_o[ch] <= '0;
      else if (fall_i && bit_q_i == END_BIT) rx_o[ch] <= tone_i ? tone_code : rx_word;
    end
  end
endmodule

// File: rtl/pcm_burst_timer.sv
module pcm_burst_timer #(
  parameter int unsigned TIMEOUT = 600,
  parameter int unsigned TW      = $clog2(TIMEOUT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  output logic expired_o
);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);
  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (good_i)        cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcm_slave_timer.sv
module pcm_slave_timer
  import pcm_slave_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned TIMEOUT    = 600,
  parameter byte_t       TONE_A     = 8'h2A,
  parameter byte_t       TONE_B     = 8'hAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             good_burst_i,
  input  logic             tone_i,
  input  logic             rx_i,
  input  logic [7:0]       tx1_i,
  input  logic [7:0]       tx2_i,
  output logic             bclk_o,
  output logic             en1_o,
  output logic             en2_o,
  output logic             tx_o,
  output logic [7:0]       rx1_o,
  output logic [7:0]       rx2_o,
  output logic             lost_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);

  logic             rise, fall, sof, tone_sel, expired, lost_q;
  logic [CNT_W-1:0] bit_q, bit_nxt;
  byte_t [1:0]      rx_b;

  pcm_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk_i, .rst_ni, .div_i,
    .bclk_o, .rise_o(rise), .fall_o(fall)
  );

  pcm_frame_seq #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .rise_i(rise),
    .bit_q_o(bit_q), .bit_nxt_o(bit_nxt), .sof_o(sof),
    .tone_sel_o(tone_sel), .en1_o, .en2_o
  );

  pcm_serdes #(.CNT_W(CNT_W), .TONE_A(TONE_A), .TONE_B(TONE_B)) u_sd (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall),
    .bit_q_i(bit_q), .bit_nxt_i(bit_nxt), .tone_sel_i(tone_sel),
    .tone_i, .rx_i, .tx1_i, .tx2_i, .tx_o, .rx_o(rx_b)
  );

  pcm_burst_timer #(.TIMEOUT(TIMEOUT)) u_bt (
    .clk_i, .rst_ni, .good_i(good_burst_i), .expired_o(expired)
  );

  // status sampled only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  lost_q <= 1'b0;
    else if (sof) lost_q <= expired;
  end

  assign lost_o = lost_q;
  assign rx1_o  = rx_b[0];
  assign rx2_o  = rx_b[1];
endmodule

// File: rtl/pcm_slave_timer_chk.sv
module pcm_slave_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bclk_o,
  input logic       en1_o,
  input logic       en2_o,
  input logic       tx_o,
  input logic [7:0] rx1_o,
  input logic [7:0] rx2_o,
  input logic       lost_o
);
  // R3
  en_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en1_o && en2_o));

  // R3
  en1_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en1_o) |-> $rose(bclk_o));

  // R3
  en2_follows_en1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en2_o) |-> $fell(en1_o));

  // R4
  tx_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(bclk_o) |-> $stable(tx_o));

  // R5
  rx1_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(bclk_o) |-> $stable(rx1_o));

  // R5
  rx2_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(bclk_o) |-> $stable(rx2_o));

  // R8
  lost_at_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(en1_o) |-> $stable(lost_o));
endmodule

bind pcm_slave_timer pcm_slave_timer_chk u_chk (.*);

// File: tb/tb_pcm_slave_timer.sv
module tb_pcm_slave_timer;
  localparam int FB      = 32;
  localparam int T_OUT   = 600;
  localparam logic [7:0] TA = 8'h2A;
  localparam logic [7:0] TB = 8'hAA;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = '0;
  logic       good_burst_i = 1'b0, tone_i = 1'b0, rx_i = 1'b0;
  logic [7:0] tx1_i = 8'h00, tx2_i = 8'h00;
  logic       bclk_o, en1_o, en2_o, tx_o, lost_o;
  logic [7:0] rx1_o, rx2_o;

  pcm_slave_timer dut (.clk_i(clk), .*);

  always #5 clk = ~clk;

  int nchk = 0, nbad = 0, cyc = 0;
  int ecount, half_cnt, rise_no, frame_no, ef, eg_last, eg_prev, fl;
  int gmod, force_mode, coinc;
  logic prev_bclk, tone_cur;
  logic [7:0] exp_tx1, exp_tx2, rxb1, rxb2;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] tone_for(input int f);
    return (f % 16 < 8) ? TA : TB;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nbad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      ecount++;
      half_cnt++;
      if (bclk_o != prev_bclk) begin
        // R1 half period
        chk(half_cnt == int'(div_i) + 1, "R1", half_cnt, int'(div_i) + 1);
        half_cnt = 0;
        if (bclk_o) begin
          int n, eg;
          logic exp_l, ebit;
          rise_no++;
          n = rise_no % FB;
          if (n == 0) begin
            frame_no++;
            exp_tx1 = tx1_i;
            exp_tx2 = tx2_i;
            ef = ecount;
            eg = (eg_last == ef) ? eg_prev : eg_last;
            if (eg_last == ef) coinc++;
            exp_l = (ef - 1 - eg >= T_OUT);
            // R8 and R7: flag reflects watchdog state before this edge
            chk(lost_o == exp_l, "R8", lost_o, exp_l);
            rxb1 = 8'($urandom);
            rxb2 = 8'($urandom);
          end
          // R3 windows
          chk(en1_o == (n < 8), "R3", en1_o, n < 8);
          chk(en2_o == (n >= 8 && n < 16), "R3", en2_o, n >= 8 && n < 16);
          // R4 serial out
          ebit = (n < 8) ? exp_tx1[7-n] : (n < 16) ? exp_tx2[15-n] : 1'b0;
          chk(tx_o == ebit, "R4", tx_o, ebit);
          if (n == 8) begin
            // R5 / R6 channel 1
            if (tone_cur) chk(rx1_o == tone_for(frame_no), "R6", rx1_o, tone_for(frame_no));
            else          chk(rx1_o == rxb1, "R5", rx1_o, rxb1);
          end
          if (n == 16) begin
            if (tone_cur) chk(rx2_o == tone_for(frame_no), "R6", rx2_o, tone_for(frame_no));
            else          chk(rx2_o == rxb2, "R5", rx2_o, rxb2);
            tx1_i    = 8'($urandom);
            tx2_i    = 8'($urandom);
            tone_cur = ($urandom % 3 == 0);
            tone_i   = tone_cur;
          end
          rx_i = (n < 8) ? rxb1[7-n] : (n < 16) ? rxb2[15-n] : 1'($urandom);
        end
      end
      prev_bclk = bclk_o;
      // good-burst driver: sampled at edge ecount+1
      if (force_mode != 0)
        good_burst_i = (ecount == ef + fl - 1) && (frame_no % 4 == 3);
      else
        good_burst_i = ($urandom % gmod == 0);
      if (good_burst_i) begin
        eg_prev = eg_last;
        eg_last = ecount + 1;
      end
    end
  end

  task automatic run(input int dv, input int gm, input int fm, input int frames);
    @(negedge clk);
    rst_ni = 1'b0;
    good_burst_i = 1'b0;
    div_i = 8'(dv);
    repeat (3) @(negedge clk);
    // R2 reset state
    chk({bclk_o, en1_o, en2_o, tx_o, lost_o} == 5'b0, "R2", {bclk_o, en1_o, en2_o, tx_o, lost_o}, 0);
    chk(rx1_o == 8'h00 && rx2_o == 8'h00, "R2", {rx1_o, rx2_o}, 0);
    ecount = 0; half_cnt = 0; rise_no = -1; frame_no = -1;
    ef = -1000; eg_last = 0; eg_prev = 0; prev_bclk = 1'b0;
    fl = FB * 2 * (dv + 1);
    gmod = gm; force_mode = fm;
    tone_cur = 1'b0; tone_i = 1'b0;
    #1 rst_ni = 1'b1;
    while (frame_no < frames) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7));
    coinc = 0;
    run(0, 150, 0, 18);
    run(1, 5000, 0, 18);
    run(2, 1, 1, 20);   // pulses only on every fourth frame-start edge
    run(5, 700, 0, 18);
    // R8 the coincident case must have been reached
    chk(coinc >= 3, "R8", coinc, 3);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule